// File: doc/BRIEF.md
# Floating-Point Control and Status Register

This block holds the control and status word that a CPU's floating-point unit shares with software. Software writes the word to pick a rounding mode and to enable exception traps. The floating-point datapath reports raw exception flags after each operation. The block records those flags in the word, and they stay set until software overwrites the word.

The block decodes the two-bit rounding field into a one-hot selection for the arithmetic datapath. When an operation reports any flag while trapping is enabled, the block raises a one-cycle exception request toward the trap logic. The datapath and the trap logic sit outside this block. It only accumulates, stores and signals.

Top module: `fpcsr_unit`

## Requirements
- R1: A software write (`swWrEn` high) stores bits [10:0] of `swWrData`. Bits [31:11] of `regRdData` always read as zero.
- R2: Bits [2:1] of the register select the rounding mode. `roundSel` is one-hot:
  - bit 0 means round to nearest even (code 0).
  - bit 1 means toward zero (code 1).
  - bit 2 means toward +infinity (code 2).
  - bit 3 means toward -infinity (code 3).
- R3: Each raw flag ORs into its own status bit:
  - `rawFlags[0]` (invalid) sets bit 3.
  - `rawFlags[1]` (divide-by-zero) sets bit 4.
  - `rawFlags[2]` (overflow) sets bit 5.
  - `rawFlags[3]` (underflow) sets bit 6.
  - `rawFlags[4]` (inexact) sets bit 7.
  - Bits 0 to 2 and 8 to 10 change only through software writes.
- R4: Status bits are sticky. Without a software write, a set status bit stays set.
- R5: Bit 0 is the exception enable. A strobe (`flagValid`) carrying at least one raw flag, while the effective enable is 1, makes `excReq` high for exactly the following cycle.
- R6: A cycle with `flagValid` low, or with `rawFlags` all zero, leaves the register unchanged when no write is present. It also keeps `excReq` low in the next cycle.
- R7: When a write and a flag strobe arrive in the same cycle:
  - The stored value is the written value ORed with the mapped flags.
  - The enable used for the request is bit 0 of the written value.
- R8: Synchronous active-high reset clears the register to zero and drives `excReq` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| swWrEn | input | 1 | Software write strobe |
| swWrData | input | 32 | Software write value |
| flagValid | input | 1 | Flag report strobe from the datapath |
| rawFlags | input | 5 | Raw flags: [0] invalid, [1] div-by-zero, [2] overflow, [3] underflow, [4] inexact |
| regRdData | output | 32 | Register contents, zero-extended |
| roundSel | output | 4 | One-hot rounding-mode selection |
| excReq | output | 1 | One-cycle exception request |

## Verification
A corrupted register bit shows up on `regRdData` in the cycle after the update that caused it. It then persists because the flags are sticky, so every later comparison keeps exposing it.

A wrong enable, or a wrong choice of enable under a simultaneous write, appears as a missing or extra `excReq` pulse one cycle after the strobe. A misdecoded rounding field shows up on `roundSel` at once, after the write that sets it.

// File: rtl/fpcsr_pkg.sv
package fpcsr_pkg;
  localparam int DATA_W   = 32;
  localparam int CSR_W    = 11;
  localparam int FLAG_N   = 5;
  localparam int FLAG_LSB = 3;
  localparam int RM_LSB   = 1;
  localparam int RM_W     = 2;
  localparam int RM_N     = 1 << RM_W;
  localparam int EN_BIT   = 0;

  typedef struct packed {
    logic wrStb;
    logic accStb;
    logic excStb;
  } csrStrobe_t;
endpackage

// File: rtl/fpcsr_ctrl.sv
module fpcsr_ctrl
  import fpcsr_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              swWrEn,
  input  logic              wrEnableBit,
  input  logic              curEnableBit,
  input  logic              flagValid,
  input  logic [FLAG_N-1:0] rawFlags,
  output csrStrobe_t        strb,
  output logic              excReq
);
  logic hasFlag;
  logic effEnable;

  always_comb begin
    hasFlag     = flagValid && (|rawFlags);
    effEnable   = swWrEn ? wrEnableBit : curEnableBit;
    strb.wrStb  = swWrEn;
    strb.accStb = hasFlag;
    strb.excStb = hasFlag && effEnable;
  end

  always_ff @(posedge clk) begin
    if (rst) excReq <= 1'b0;
    else     excReq <= strb.excStb;
  end
endmodule

// File: rtl/fpcsr_dp.sv
module fpcsr_dp
  import fpcsr_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  csrStrobe_t        strb,
  input  logic [DATA_W-1:0] swWrData,
  input  logic [FLAG_N-1:0] rawFlags,
  output logic [CSR_W-1:0]  csrQ,
  output logic [RM_N-1:0]   roundSel
);
  localparam int HI_PAD = CSR_W - FLAG_LSB - FLAG_N;

  logic [CSR_W-1:0] mappedFlags;
  logic [CSR_W-1:0] baseVal;
  logic [CSR_W-1:0] nextVal;

  always_comb begin
    mappedFlags = {{HI_PAD{1'b0}}, rawFlags, {FLAG_LSB{1'b0}}};
    baseVal     = strb.wrStb ? swWrData[CSR_W-1:0] : csrQ;
    nextVal     = strb.accStb ? (baseVal | mappedFlags) : baseVal;
  end

  always_ff @(posedge clk) begin
    if (rst) csrQ <= '0;
    else     csrQ <= nextVal;
  end

  logic [RM_W-1:0] rmField;
  assign rmField = csrQ[RM_LSB +: RM_W];

  for (genvar gi = 0; gi < RM_N; gi++) begin : g_rmdec
    assign roundSel[gi] = (rmField == RM_W'(gi));
  end
endmodule

// File: rtl/fpcsr_unit.sv
module fpcsr_unit
  import fpcsr_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              swWrEn,
  input  logic [DATA_W-1:0] swWrData,
  input  logic              flagValid,
  input  logic [FLAG_N-1:0] rawFlags,
  output logic [DATA_W-1:0] regRdData,
  output logic [RM_N-1:0]   roundSel,
  output logic              excReq
);
  csrStrobe_t       strb;
  logic [CSR_W-1:0] csrQ;

  fpcsr_ctrl u_ctrl (
    .clk          (clk),
    .rst          (rst),
    .swWrEn       (swWrEn),
    .wrEnableBit  (swWrData[EN_BIT]),
    .curEnableBit (csrQ[EN_BIT]),
    .flagValid    (flagValid),
    .rawFlags     (rawFlags),
    .strb         (strb),
    .excReq       (excReq)
  );

  fpcsr_dp u_dp (
    .clk      (clk),
    .rst      (rst),
    .strb     (strb),
    .swWrData (swWrData),
    .rawFlags (rawFlags),
    .csrQ     (csrQ),
    .roundSel (roundSel)
  );

  assign regRdData = {{(DATA_W-CSR_W){1'b0}}, csrQ};
endmodule

// File: rtl/fpcsr_unit_chk.sv
module fpcsr_unit_chk
  import fpcsr_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              swWrEn,
  input logic [DATA_W-1:0] swWrData,
  input logic              flagValid,
  input logic [FLAG_N-1:0] rawFlags,
  input logic [DATA_W-1:0] regRdData,
  input logic [RM_N-1:0]   roundSel,
  input logic              excReq
);
  logic anyFlag;
  assign anyFlag = flagValid && (|rawFlags);

  p_upper_zero_r1: assert property (@(posedge clk) disable iff (rst)
    regRdData[DATA_W-1:CSR_W] == '0);

  p_onehot_rm_r2: assert property (@(posedge clk) disable iff (rst)
    $countones(roundSel) == 1);

  p_sticky_r4: assert property (@(posedge clk) disable iff (rst)
    !swWrEn |=> ((regRdData[7:3] & $past(regRdData[7:3])) == $past(regRdData[7:3])));

  p_exc_fire_r5: assert property (@(posedge clk) disable iff (rst)
    (anyFlag && (swWrEn ? swWrData[EN_BIT] : regRdData[EN_BIT])) |=> excReq);

  p_no_exc_r6: assert property (@(posedge clk) disable iff (rst)
    !anyFlag |=> !excReq);

  p_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (!swWrEn && !anyFlag) |=> $stable(regRdData));

  p_write_r7: assert property (@(posedge clk) disable iff (rst)
    (swWrEn && !anyFlag) |=> regRdData[CSR_W-1:0] == $past(swWrData[CSR_W-1:0]));

  p_reset_r8: assert property (@(posedge clk)
    rst |=> (regRdData == '0 && !excReq));
endmodule

bind fpcsr_unit fpcsr_unit_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .swWrEn    (swWrEn),
  .swWrData  (swWrData),
  .flagValid (flagValid),
  .rawFlags  (rawFlags),
  .regRdData (regRdData),
  .roundSel  (roundSel),
  .excReq    (excReq)
);

// File: tb/fpcsr_unit_test.sv
module fpcsr_unit_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic        swWrEn;
  logic [31:0] swWrData;
  logic        flagValid;
  logic [4:0]  rawFlags;
  logic [31:0] regRdData;
  logic [3:0]  roundSel;
  logic        excReq;

  always #(CLK_PERIOD/2) clk = ~clk;

  fpcsr_unit uut (
    .clk(clk), .rst(rst), .swWrEn(swWrEn), .swWrData(swWrData),
    .flagValid(flagValid), .rawFlags(rawFlags),
    .regRdData(regRdData), .roundSel(roundSel), .excReq(excReq)
  );

  typedef struct {
    logic [31:0] expReg;
    logic        expExc;
    logic [3:0]  expRs;
    string       tag;
  } expItem_t;

  expItem_t    sbQ[$];
  int          nCompared = 0;
  int          nMismatch = 0;
  logic [10:0] modelReg = '0;
  bit          done = 0;

  task automatic step(input logic r, input logic we, input logic [31:0] wd,
                      input logic fv, input logic [4:0] rf, input string tag);
    expItem_t    it;
    logic [10:0] nv;
    logic        ex;
    @(negedge clk);
    rst = r; swWrEn = we; swWrData = wd; flagValid = fv; rawFlags = rf;
    if (r) begin
      nv = '0; ex = 1'b0;
    end else begin
      nv = we ? wd[10:0] : modelReg;
      if (fv) nv = nv | {3'b000, rf, 3'b000};
      ex = fv && (rf != 0) && nv[0];
    end
    modelReg  = nv;
    it.expReg = {21'd0, nv};
    it.expExc = ex;
    it.expRs  = 4'b0001 << nv[2:1];
    it.tag    = tag;
    sbQ.push_back(it);
  endtask

  initial begin : monitor
    expItem_t it;
    forever begin
      @(posedge clk);
      #1;
      if (sbQ.size() > 0) begin
        it = sbQ.pop_front();
        nCompared++;
        if (regRdData !== it.expReg || excReq !== it.expExc || roundSel !== it.expRs) begin
          nMismatch++;
          $display("FAIL %s: reg=%h exc=%b rs=%b expected reg=%h exc=%b rs=%b",
                   it.tag, regRdData, excReq, roundSel, it.expReg, it.expExc, it.expRs);
        end
      end
    end
  end

  initial begin : watchdog
    #(CLK_PERIOD * 5000);
    if (!done) begin
      nMismatch++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCompared, nMismatch);
      $finish;
    end
  end

  initial begin : driver
    rst = 1'b1; swWrEn = 0; swWrData = '0; flagValid = 0; rawFlags = '0;
    step(1, 0, 32'h0, 0, 5'h0, "R8 reset");
    step(1, 1, 32'hFFFF_FFFF, 1, 5'h1F, "R8 reset dominates");
    // R1 masking, R2 each rounding code
    step(0, 1, 32'hFFFF_F802, 0, 5'h0, "R1 upper bits dropped, R2 code 1");
    step(0, 1, 32'h0000_0004, 0, 5'h0, "R2 code 2");
    step(0, 1, 32'h0000_0006, 0, 5'h0, "R2 code 3");
    step(0, 1, 32'h0000_0000, 0, 5'h0, "R2 code 0");
    // R3 each flag alone, enable off
    for (int i = 0; i < 5; i++) begin
      step(0, 1, 32'h0, 0, 5'h0, "R3 clear");
      step(0, 0, 32'h0, 1, 5'(1 << i), "R3 single flag mapping");
    end
    // R4 stickiness, R6 no-flag cycles
    step(0, 1, 32'h0, 0, 5'h0, "R4 clear");
    step(0, 0, 32'h0, 1, 5'b00100, "R4 overflow set");
    step(0, 0, 32'h0, 1, 5'b10000, "R4 inexact accumulates");
    step(0, 0, 32'h0, 0, 5'b11111, "R6 strobe low ignored");
    step(0, 0, 32'h0, 1, 5'b00000, "R6 empty strobe ignored");
    step(0, 0, 32'h0, 0, 5'h0, "R4 still held");
    // R5 enable on
    step(0, 1, 32'h0000_0701, 0, 5'h0, "R1 spare bits written, enable on");
    step(0, 0, 32'h0, 1, 5'b00010, "R5 exception request");
    step(0, 0, 32'h0, 0, 5'h0, "R5 pulse one cycle only");
    step(0, 0, 32'h0, 1, 5'b00010, "R5 repeated flag still requests");
    step(0, 0, 32'h0, 1, 5'b00000, "R6 no flags no request");
    // R7 write+flags same cycle
    step(0, 1, 32'h0000_0000, 1, 5'b01000, "R7 write disables, no request");
    step(0, 1, 32'h0000_0003, 1, 5'b00001, "R7 write enables, request");
    step(0, 0, 32'h0, 0, 5'h0, "R7 idle");
    step(0, 1, 32'h0000_0000, 0, 5'h0, "R4 write clears flags");
    step(0, 0, 32'h0, 1, 5'b11111, "R3 all flags");
    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCompared, nMismatch);
    $finish;
  end
endmodule